// File: doc/BRIEF.md
# Base Address Region Map Validator

This block judges the address windows of a configuration-space header. It covers six standard base registers and one expansion-ROM register. For each region it receives the programmed register value, the region size and whether the region decodes I/O or memory space. It also receives the two space-enable bits of the command register. From these it decides whether the region is currently mapped and, when it is, at which aligned base.

Evaluation happens only when an update request arrives. The results are registered one clock later. They are then held until the next request, so the surrounding logic can ask for a re-check after any write that may have moved a window. Each region also has a one-cycle change strobe. The strobe fires only when that region's mapped state or base really moved, which tells the address decoder to retire the old window and open the new one. The decoding itself happens outside this block.

Top module: `bar_map_check`

## Requirements
- R1: While rst_ni is low, and after it is released, every map_valid_o bit, every map_base_o field and every map_change_o bit is 0.
- R2: Outputs change only on the rising clock edge at which update_i is 1, and become visible in the cycle after that request. Without a request, map_valid_o and map_base_o hold and map_change_o is 0.
- R3: A mapped region's base is its register value with the low log2(size) bits cleared, i.e. value AND NOT(size-1). Region n occupies field bits [32n+31:32n] of bar_val_i, bar_size_i and map_base_o.
- R4: A region whose size is 0 is unimplemented and is never reported as mapped.
- R5: An I/O region (bar_io_i bit = 1) can be mapped only when cmd_io_en_i is 1. A memory region (bar_io_i bit = 0) can be mapped only when cmd_mem_en_i is 1.
- R6: An I/O region is unmapped when its aligned base is 0, when its end address (base+size-1, modulo 2^32) is not above the base, or when its end is 0x10000 or higher.
- R7: A memory region is unmapped when its aligned base is 0, when its end is not above the base, or when its end is 0xFFFFFFFF.
- R8: The ROM region is index 6, the highest. As a memory region it is mapped only when bit 0 of its register value is 1.
- R9: An unmapped region reports map_valid_o = 0 and a base of 0.
- R10: map_change_o for a region is 1 for exactly the one cycle after a request if the region's (valid, base) pair differs from the pair held before. If the pair is the same, the bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Re-evaluate all regions at this edge |
| cmd_io_en_i | input | 1 | Command register I/O-space enable |
| cmd_mem_en_i | input | 1 | Command register memory-space enable |
| bar_val_i | input | 224 | Register values, 32 bits per region, region 6 is ROM |
| bar_size_i | input | 224 | Region sizes, a power of two or 0 |
| bar_io_i | input | 7 | Per region: 1 = I/O space, 0 = memory space |
| map_valid_o | output | 7 | Per region: region is mapped |
| map_base_o | output | 224 | Per region aligned base, 0 when unmapped |
| map_change_o | output | 7 | Per region one-cycle strobe on a moved mapping |

## Verification
The bench builds the block with six standard regions plus the ROM region and a 32-bit address width, and uses the default 64K I/O limit. With these values both end-of-range rules are reachable. An I/O window just under 0x10000 is accepted and one starting at 0x10000 is rejected, while a memory window ending at 0xFFFFFFFF is rejected. A size-1 window exercises the end-not-above-base rule. The ROM enable bit, both command enables and repeated identical requests are also driven. Identical requests show that the change strobe stays quiet.

// File: rtl/bar_map_pkg.sv
package bar_map_pkg;
  typedef enum logic {SPACE_MEM = 1'b0, SPACE_IO = 1'b1} space_e;
  localparam int unsigned DEF_AW       = 32;
  localparam int unsigned DEF_NUM_BARS = 6;
  localparam int unsigned DEF_IO_LIMIT = 32'h0001_0000;
endpackage

// File: rtl/bar_region_eval.sv
module bar_region_eval #(
  parameter int unsigned AW       = bar_map_pkg::DEF_AW,
  parameter int unsigned IO_LIMIT = bar_map_pkg::DEF_IO_LIMIT,
  parameter bit          IS_ROM   = 1'b0
) (
  input  logic [AW-1:0]          val_i,
  input  logic [AW-1:0]          size_i,
  input  bar_map_pkg::space_e    space_i,
  input  logic                   io_en_i,
  input  logic                   mem_en_i,
  output logic                   valid_o,
  output logic [AW-1:0]          base_o
);
  import bar_map_pkg::*;

  localparam logic [AW-1:0] IO_LIM = AW'(IO_LIMIT);
  localparam logic [AW-1:0] ONE    = AW'(1);

  logic [AW-1:0] aligned, last;
  logic          span_ok, io_ok, mem_ok, rom_gate;

  assign aligned = val_i & ~(size_i - ONE);
  assign last    = aligned + size_i - ONE;
  // wrap or size-1 window gives last <= aligned
  assign span_ok = (aligned != '0) && (last > aligned);
  assign io_ok   = io_en_i && span_ok && (last < IO_LIM);

  generate
    if (IS_ROM) begin : g_rom
      assign rom_gate = val_i[0];
    end else begin : g_std
      assign rom_gate = 1'b1;
    end
  endgenerate

  assign mem_ok  = mem_en_i && rom_gate && span_ok && (last != '1);

  always_comb begin
    valid_o = 1'b0;
    if (size_i != '0) begin
      valid_o = (space_i == SPACE_IO) ? io_ok : mem_ok;
    end
    base_o = valid_o ? aligned : '0;
  end
endmodule

// File: rtl/bar_map_slot.sv
module bar_map_slot #(
  parameter int unsigned AW = bar_map_pkg::DEF_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          update_i,
  input  logic          nxt_valid_i,
  input  logic [AW-1:0] nxt_base_i,
  output logic          valid_o,
  output logic [AW-1:0] base_o,
  output logic          change_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      base_o   <= '0;
      change_o <= 1'b0;
    end else if (update_i) begin
      valid_o  <= nxt_valid_i;
      base_o   <= nxt_base_i;
      change_o <= (nxt_valid_i != valid_o) || (nxt_base_i != base_o);
    end else begin
      change_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bar_map_check.sv
module bar_map_check #(
  parameter int unsigned NUM_BARS = bar_map_pkg::DEF_NUM_BARS,
  parameter int unsigned AW       = bar_map_pkg::DEF_AW,
  parameter int unsigned IO_LIMIT = bar_map_pkg::DEF_IO_LIMIT,
  localparam int unsigned NR      = NUM_BARS + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             update_i,
  input  logic             cmd_io_en_i,
  input  logic             cmd_mem_en_i,
  input  logic [NR*AW-1:0] bar_val_i,
  input  logic [NR*AW-1:0] bar_size_i,
  input  logic [NR-1:0]    bar_io_i,
  output logic [NR-1:0]    map_valid_o,
  output logic [NR*AW-1:0] map_base_o,
  output logic [NR-1:0]    map_change_o
);
  import bar_map_pkg::*;

  for (genvar i = 0; i < NR; i++) begin : g_region
    logic          nxt_valid;
    logic [AW-1:0] nxt_base;

    bar_region_eval #(
      .AW       (AW),
      .IO_LIMIT (IO_LIMIT),
      .IS_ROM   (i == NR - 1)
    ) i_eval (
      .val_i    (bar_val_i[i*AW +: AW]),
      .size_i   (bar_size_i[i*AW +: AW]),
      .space_i  (space_e'(bar_io_i[i])),
      .io_en_i  (cmd_io_en_i),
      .mem_en_i (cmd_mem_en_i),
      .valid_o  (nxt_valid),
      .base_o   (nxt_base)
    );

    bar_map_slot #(.AW(AW)) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .update_i    (update_i),
      .nxt_valid_i (nxt_valid),
      .nxt_base_i  (nxt_base),
      .valid_o     (map_valid_o[i]),
      .base_o      (map_base_o[i*AW +: AW]),
      .change_o    (map_change_o[i])
    );
  end
endmodule

// File: rtl/bar_map_check_sva.sv
module bar_map_check_sva #(
  parameter int unsigned NUM_BARS = 6,
  parameter int unsigned AW       = 32,
  localparam int unsigned NR      = NUM_BARS + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             update_i,
  input logic             cmd_io_en_i,
  input logic             cmd_mem_en_i,
  input logic [NR*AW-1:0] bar_val_i,
  input logic [NR*AW-1:0] bar_size_i,
  input logic [NR-1:0]    bar_io_i,
  input logic [NR-1:0]    map_valid_o,
  input logic [NR*AW-1:0] map_base_o,
  input logic [NR-1:0]    map_change_o
);
  AST_NO_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> map_change_o == '0); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(map_valid_o) && $stable(map_base_o)); // R2

  for (genvar i = 0; i < NR; i++) begin : g_chk
    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !map_valid_o[i] |-> map_base_o[i*AW +: AW] == '0); // R9
    AST_MAPPED_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      map_valid_o[i] |-> map_base_o[i*AW +: AW] != '0); // R7
    AST_UNIMPL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      update_i && bar_size_i[i*AW +: AW] == '0 |=> !map_valid_o[i]); // R4
    AST_IO_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      update_i && bar_io_i[i] && !cmd_io_en_i |=> !map_valid_o[i]); // R5
    AST_MEM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      update_i && !bar_io_i[i] && !cmd_mem_en_i |=> !map_valid_o[i]); // R5
    AST_STROBE_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      map_change_o[i] |-> (map_valid_o[i] != $past(map_valid_o[i]))
                       || (map_base_o[i*AW +: AW] != $past(map_base_o[i*AW +: AW]))); // R10
    if (i == NR - 1) begin : g_rom
      AST_ROM_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        update_i && !bar_io_i[i] && !bar_val_i[i*AW] |=> !map_valid_o[i]); // R8
    end
  end
endmodule

bind bar_map_check bar_map_check_sva #(.NUM_BARS(NUM_BARS), .AW(AW)) i_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .update_i     (update_i),
  .cmd_io_en_i  (cmd_io_en_i),
  .cmd_mem_en_i (cmd_mem_en_i),
  .bar_val_i    (bar_val_i),
  .bar_size_i   (bar_size_i),
  .bar_io_i     (bar_io_i),
  .map_valid_o  (map_valid_o),
  .map_base_o   (map_base_o),
  .map_change_o (map_change_o)
);

// File: tb/test_bar_map_check.sv
`timescale 1ns/1ps
module test_bar_map_check;
  localparam int NB = 6;
  localparam int AW = 32;
  localparam int NR = NB + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, update_i = 1'b0;
  logic cmd_io_en_i = 1'b0, cmd_mem_en_i = 1'b0;
  logic [NR*AW-1:0] bar_val_i = '0, bar_size_i = '0, map_base_o;
  logic [NR-1:0] bar_io_i = '0, map_valid_o, map_change_o;

  int errors = 0, checks = 0;
  bit model_on = 1'b0;
  bit exp_v [NR];
  logic [31:0] exp_b [NR];
  bit exp_c [NR];

  always #10 clk_i = ~clk_i;

  bar_map_check #(.NUM_BARS(NB), .AW(AW), .IO_LIMIT(32'h1_0000)) i_bar_map_check (
    .clk_i, .rst_ni, .update_i, .cmd_io_en_i, .cmd_mem_en_i,
    .bar_val_i, .bar_size_i, .bar_io_i, .map_valid_o, .map_base_o, .map_change_o
  );

  function automatic void ref_map(input logic [31:0] v, input logic [31:0] s,
                                  input bit io, input bit rom, input bit ioen,
                                  input bit memen, output bit ok, output logic [31:0] b);
    longint unsigned base, last;
    ok = 1'b0;
    b  = '0;
    if (s == 0) return;
    base = longint'(v & ~(s - 32'd1));
    last = (base + longint'(s) - 1) & 64'hFFFF_FFFF;
    if (io) ok = ioen && base != 0 && last > base && last < 64'h1_0000;
    else    ok = memen && (!rom || v[0]) && base != 0 && last > base && last != 64'hFFFF_FFFF;
    if (ok) b = base[31:0];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NR; i++) begin exp_v[i] = 0; exp_b[i] = '0; exp_c[i] = 0; end
    end else if (update_i) begin
      for (int i = 0; i < NR; i++) begin
        bit ok; logic [31:0] b;
        ref_map(bar_val_i[i*AW +: AW], bar_size_i[i*AW +: AW], bar_io_i[i],
                i == NR - 1, cmd_io_en_i, cmd_mem_en_i, ok, b);
        exp_c[i] = (ok != exp_v[i]) || (b != exp_b[i]);
        exp_v[i] = ok;
        exp_b[i] = b;
      end
    end else begin
      for (int i = 0; i < NR; i++) exp_c[i] = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (model_on && rst_ni) begin
      for (int i = 0; i < NR; i++) begin
        checks++;
        if (map_valid_o[i] !== exp_v[i] || map_base_o[i*AW +: AW] !== exp_b[i]
            || map_change_o[i] !== exp_c[i]) begin
          errors++;
          $display("FAIL R2/R10 model region %0d: got v=%0b b=%h c=%0b exp v=%0b b=%h c=%0b",
                   i, map_valid_o[i], map_base_o[i*AW +: AW], map_change_o[i],
                   exp_v[i], exp_b[i], exp_c[i]);
        end
      end
    end
  end

  task automatic chk(input int i, input bit ev, input logic [31:0] eb, input bit ec,
                     input string req);
    checks++;
    if (map_valid_o[i] !== ev || map_base_o[i*AW +: AW] !== eb || map_change_o[i] !== ec) begin
      errors++;
      $display("FAIL %s region %0d: got v=%0b b=%h c=%0b exp v=%0b b=%h c=%0b", req, i,
               map_valid_o[i], map_base_o[i*AW +: AW], map_change_o[i], ev, eb, ec);
    end
  endtask

  task automatic set_bar(input int i, input logic [31:0] v, input logic [31:0] s, input bit io);
    bar_val_i[i*AW +: AW]  = v;
    bar_size_i[i*AW +: AW] = s;
    bar_io_i[i]            = io;
  endtask

  // request at a negedge, results checked at the following negedge
  task automatic request();
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
    #1;
  endtask

  task automatic idle_cycle();
    @(negedge clk_i);
    #1;
  endtask

  task automatic load_base_set();
    set_bar(0, 32'h8000_1234, 32'h1000, 0);
    set_bar(1, 32'h0000_C0F1, 32'h20, 1);
    set_bar(2, 32'h1234_5678, 32'h0, 0);
    set_bar(3, 32'h0000_FFE1, 32'h20, 1);
    set_bar(4, 32'h0001_0001, 32'h10, 1);
    set_bar(5, 32'hFFFF_F000, 32'h1000, 0);
    set_bar(6, 32'hC000_0001, 32'h1_0000, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(0, 0, 32'h0, 0, "R1 in reset");
    chk(6, 0, 32'h0, 0, "R1 in reset");
    rst_ni = 1'b1;
    idle_cycle();
    chk(3, 0, 32'h0, 0, "R1 after release");
    model_on = 1'b1;

    cmd_io_en_i = 1'b1;
    cmd_mem_en_i = 1'b1;
    load_base_set();
    request();
    chk(0, 1, 32'h8000_1000, 1, "R3 memory align");
    chk(1, 1, 32'h0000_C0E0, 1, "R5 io enabled");
    chk(2, 0, 32'h0, 0, "R4 size zero");
    chk(3, 1, 32'h0000_FFE0, 1, "R6 io end below limit");
    chk(4, 0, 32'h0, 0, "R6 io end past limit");
    chk(5, 0, 32'h0, 0, "R7 memory end all ones");
    chk(6, 1, 32'hC000_0000, 1, "R8 rom enabled");

    idle_cycle();
    chk(0, 1, 32'h8000_1000, 0, "R2 strobe one cycle");
    set_bar(0, 32'h4000_0000, 32'h1000, 0);
    idle_cycle();
    chk(0, 1, 32'h8000_1000, 0, "R2 hold without request");
    set_bar(0, 32'h8000_1234, 32'h1000, 0);
    request();
    chk(0, 1, 32'h8000_1000, 0, "R10 same mapping no strobe");
    chk(6, 1, 32'hC000_0000, 0, "R10 same mapping no strobe");

    set_bar(6, 32'hC000_0000, 32'h1_0000, 0);
    set_bar(0, 32'h0000_0FFF, 32'h1000, 0);
    set_bar(3, 32'h0000_0100, 32'h1, 1);
    request();
    chk(6, 0, 32'h0, 1, "R8 rom disabled");
    chk(0, 0, 32'h0, 1, "R7 zero base");
    chk(3, 0, 32'h0, 1, "R6 end not above base");
    chk(1, 1, 32'h0000_C0E0, 0, "R10 untouched region");

    cmd_io_en_i = 1'b0;
    request();
    chk(1, 0, 32'h0, 1, "R5 io disabled");
    chk(6, 0, 32'h0, 0, "R9 unmapped stays quiet");

    cmd_io_en_i = 1'b1;
    cmd_mem_en_i = 1'b0;
    set_bar(0, 32'h4000_0000, 32'h1000, 0);
    set_bar(5, 32'h8000_0000, 32'h8000_0000, 0);
    request();
    chk(0, 0, 32'h0, 0, "R5 memory disabled");
    chk(1, 1, 32'h0000_C0E0, 1, "R5 io re-enabled");

    cmd_mem_en_i = 1'b1;
    request();
    chk(0, 1, 32'h4000_0000, 1, "R3 memory enabled");
    chk(5, 0, 32'h0, 0, "R7 top window end all ones");

    set_bar(6, 32'hC000_0001, 32'h1_0000, 0);
    set_bar(2, 32'h0000_0000, 32'h0, 1);
    request();
    chk(6, 1, 32'hC000_0000, 1, "R8 rom back on");
    chk(2, 0, 32'h0, 0, "R4 io size zero");

    rst_ni = 1'b0;
    model_on = 1'b0;
    #1;
    chk(6, 0, 32'h0, 0, "R1 async reset");
    chk(0, 0, 32'h0, 0, "R1 async reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule